// File: doc/BRIEF.md
# Asynchronous SRAM cycle sequencer

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 512K words by 8 bits. The requester offers one access at a time on a valid/ready port that carries a read/write flag, a 19-bit address and a write byte. The block then drives the memory's address, active-low chip enable, output enable and write enable, together with a data driver that has its own enable. Read bytes return on a separate port with a one-cycle valid strobe.

Every memory timing minimum is a parameter in picoseconds. A clock-period parameter turns each one into a cycle count by rounding up, so a nonzero limit never costs less than one cycle and a zero limit costs none. A mode parameter chooses one of two write styles. In the first, output enable stays high for the whole write. In the second, output enable stays low while write enable is low. The second style needs the longer write-enable pulse, and it also has to wait for the memory's outputs to reach high impedance before the block drives data.

Top module: `asram_seq`

## Requirements
- R1: During and right after reset the memory strobes (chip, output and write enable) are high, the data driver is off, req_ready is 1 and rsp_valid is 0.
- R2: A read holds chip enable and output enable low, write enable high and the address constant for max(ceil(tAA), ceil(tRC)) cycles. The byte on mem_dq_in is captured on the clock edge that ends the ceil(tAA)-th cycle, and it appears on rsp_rdata with rsp_valid high in the cycle after that edge.
- R3: A write holds write enable low only while chip enable is low, and the address stays equal to the requested address throughout. The byte read back later from that address equals the written byte.
- R4: With OE_LOW_WR=0, output enable stays high throughout a write. With OE_LOW_WR=1, it is low in every cycle where write enable is low, and high once write enable has risen.
- R5: The data driver is on for the write-enable-low cycles that come after the high-impedance wait: ceil(tHZWE) cycles when OE_LOW_WR=1, none when it is 0. It is never on while the memory could be driving the bus.
- R6: The cycle after write enable rises is a single hold cycle. In it chip enable is low, output enable is high, the driver is still on, and address and data are unchanged.
- R7: req_ready is low for exactly the access length: max(W+1, ceil(tWC)) cycles for a write and max(ceil(tAA), ceil(tRC)) cycles for a read. With req_valid held high, two accepts are always one access length plus one idle cycle apart.
- R8: The write-enable low width W is max(ceil(tPWE), ceil(tAW), wait+ceil(tSD)). Here tPWE is the high-output-enable minimum when OE_LOW_WR=0 and the low-output-enable minimum when OE_LOW_WR=1. With the defaults and an 8 ns clock, W is 1 cycle for OE_LOW_WR=0 and 2 cycles for OE_LOW_WR=1.
- R9: rsp_valid is a single-cycle pulse given exactly once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle; a request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Byte driven to the memory bus |
| mem_dq_oe | output | 1 | Enable for the bus driver |
| mem_dq_in | input | 8 | Byte sampled from the memory bus |

## Verification
Some pin rules are checked by the assertions on every cycle. Write enable is never low without chip enable. The driver never overlaps a memory read. The address does not move while chip enable is low. The rise of write enable is followed by a hold cycle with the driver still on. The output-enable level during a write matches the selected mode. The read-valid strobe lasts a single cycle. Only the bench's scenarios can show the rest: the exact cycle counts derived from the nanosecond limits in both write modes, that written bytes survive to a later read, that a bus model which drives until its high-impedance time has passed is never fought, and that held requests are spaced correctly.

// File: rtl/asram_seq.sv
module asram_seq #(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int CLK_PS       = 8000,
  parameter int T_RC_PS      = 10000,
  parameter int T_AA_PS      = 10000,
  parameter int T_WC_PS      = 10000,
  parameter int T_AW_PS      = 8000,
  parameter int T_PWE_PS     = 8000,
  parameter int T_PWE_OEL_PS = 10000,
  parameter int T_SD_PS      = 6000,
  parameter int T_HZWE_PS    = 5000,
  parameter bit OE_LOW_WR    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AA   = imax(cyc(T_AA_PS), 1);
  localparam int RLEN = imax(AA, cyc(T_RC_PS));
  localparam int HZW  = OE_LOW_WR ? cyc(T_HZWE_PS) : 0;
  localparam int PWE  = OE_LOW_WR ? cyc(T_PWE_OEL_PS) : cyc(T_PWE_PS);
  localparam int WLO  = imax(imax(imax(PWE, cyc(T_AW_PS)), HZW + cyc(T_SD_PS)), 1);
  localparam int WLEN = imax(WLO + 1, cyc(T_WC_PS));
  localparam int CW   = $clog2(imax(WLEN, RLEN) + 1);

  localparam logic [CW-1:0] WLO_C   = CW'(WLO);
  localparam logic [CW-1:0] HZW_C   = CW'(HZW);
  localparam logic [CW-1:0] AA_LAST = CW'(AA - 1);
  localparam logic [CW-1:0] W_LAST  = CW'(WLEN - 1);
  localparam logic [CW-1:0] R_LAST  = CW'(RLEN - 1);

  logic              busy, wr, rsp_q;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ph_wlo, ph_hold, ph_rd, cap;

  assign ph_wlo  = busy && wr && (cnt < WLO_C);
  assign ph_hold = busy && wr && (cnt == WLO_C);
  assign ph_rd   = busy && !wr;
  assign cap     = ph_rd && (cnt == AA_LAST);

  assign req_ready  = !busy;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = !(ph_wlo || ph_hold || ph_rd);
  assign mem_we_n   = !ph_wlo;
  assign mem_oe_n   = !(ph_rd || (OE_LOW_WR && ph_wlo));
  assign mem_dq_oe  = (ph_wlo && (cnt >= HZW_C)) || ph_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr      <= 1'b0;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= cap;
      if (cap) rdata_q <= mem_dq_in;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          wr      <= req_write;
          cnt     <= '0;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
      end else if (cnt == (wr ? W_LAST : R_LAST)) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n || !mem_we_n));

  p_oe_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n == !OE_LOW_WR));

  p_hold_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mem_we_n) && mem_we_n) |-> (!mem_ce_n && mem_oe_n && mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_idle_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/asram_seq_tb.sv
module asram_seq_tb_lane #(parameter bit OEL = 1'b0) (
  input logic clk,
  input logic rst_n
);
  localparam int CLK = 8000;
  function automatic int cc(input int ps); return (ps + CLK - 1) / CLK; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  localparam int E_AA   = cc(10000);
  localparam int E_RLEN = mx(E_AA, cc(10000));
  localparam int E_HZ   = OEL ? cc(5000) : 0;
  localparam int E_PWE  = OEL ? cc(10000) : cc(8000);
  localparam int E_WLO  = mx(mx(E_PWE, cc(8000)), E_HZ + cc(6000));
  localparam int E_WLEN = mx(E_WLO + 1, cc(10000));

  logic        rv = 1'b0, rw = 1'b0;
  logic [18:0] ra = '0;
  logic [7:0]  rd = '0;
  logic        rdy, rsp, ce, oe, we, doe;
  logic [7:0]  rdata, dout;
  logic [18:0] maddr;
  logic [7:0]  din = 8'h00;

  asram_seq #(.CLK_PS(CLK), .OE_LOW_WR(OEL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_ready(rdy), .req_write(rw),
    .req_addr(ra), .req_wdata(rd), .rsp_valid(rsp), .rsp_rdata(rdata),
    .mem_addr(maddr), .mem_ce_n(ce), .mem_oe_n(oe), .mem_we_n(we),
    .mem_dq_out(dout), .mem_dq_oe(doe), .mem_dq_in(din));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s lane_oel=%0d %s actual=%0d expected=%0d", rq, OEL, what, act, exp);
    end
  endtask

  logic [7:0]  mem [logic [18:0]];
  logic [7:0]  shadow [logic [18:0]];
  bit          ov_q = 1'b0;
  logic [18:0] ov_a = '0;
  logic [7:0]  ov_d = '0;
  int          we_run = 0;

  always @(negedge clk) begin
    bit ov, mdrv;
    ov = !ce && !we;
    if (ov) begin ov_a = maddr; ov_d = doe ? dout : 8'hEE; end
    if (ov_q && !ov) mem[ov_a] = ov_d;
    ov_q = ov;
    mdrv = !ce && !oe && (we || we_run < E_HZ);
    if (rst_n && doe) chk(!mdrv, "R5", int'(mdrv), 0, "driver on while memory drives");
    we_run = we ? 0 : we_run + 1;
    din = (!ce && !oe && we && mem.exists(maddr)) ? mem[maddr] : 8'h00;
  end

  function automatic logic [7:0] pat(input logic [18:0] a);
    return 8'(a ^ (a >> 8) ^ (a >> 16)) ^ (OEL ? 8'hC3 : 8'h5A);
  endfunction

  task automatic start(input bit w, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); rv = 1'b1; rw = w; ra = a; rd = d;
    while (!rdy) @(negedge clk);
    @(negedge clk); rv = 1'b0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int busy = 0, welo = 0, drv = 0, oebad = 0, abad = 0, holds = 0, nrsp = 0;
    bit prev_low = 1'b0;
    start(1'b1, a, d);
    for (int k = 1; k <= E_WLEN + 2; k++) begin
      if (!rdy) busy++;
      if (rsp) nrsp++;
      if (!we) begin
        welo++;
        if (doe) drv++;
        if (oe != !OEL) oebad++;
        if (ce || maddr != a) abad++;
      end else if (prev_low) begin
        holds++;
        chk(!ce && oe && doe && maddr == a && dout == d, "R6", int'(dout), int'(d), "hold cycle pins");
      end
      prev_low = !we;
      @(negedge clk);
    end
    chk(welo == E_WLO, "R8", welo, E_WLO, "write-enable low cycles");
    chk(drv == E_WLO - E_HZ, "R5", drv, E_WLO - E_HZ, "driver cycles while write enable low");
    chk(oebad == 0, "R4", oebad, 0, "output enable level during write");
    chk(abad == 0, "R3", abad, 0, "chip enable or address wrong during write");
    chk(holds == 1, "R6", holds, 1, "hold cycles");
    chk(busy == E_WLEN, "R7", busy, E_WLEN, "write busy cycles");
    chk(nrsp == 0, "R9", nrsp, 0, "response during write");
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [18:0] a);
    int busy = 0, bad = 0, nrsp = 0, rk = -1;
    logic [7:0] got = '0;
    start(1'b0, a, 8'h00);
    for (int k = 1; k <= E_RLEN + 2; k++) begin
      if (!rdy) begin
        busy++;
        if (ce || oe || !we || doe || maddr != a) bad++;
      end
      if (rsp) begin nrsp++; rk = k; got = rdata; end
      @(negedge clk);
    end
    chk(bad == 0, "R2", bad, 0, "read pin levels");
    chk(nrsp == 1, "R9", nrsp, 1, "responses per read");
    chk(rk == E_AA + 1, "R2", rk, E_AA + 1, "response cycle after accept");
    chk(got == shadow[a], "R3", int'(got), int'(shadow[a]), "read-back byte");
    chk(busy == E_RLEN, "R7", busy, E_RLEN, "read busy cycles");
  endtask

  task automatic b2b(input logic [18:0] a, input int n);
    int last = -1, nacc = 0, nrsp = 0;
    bit drop = 1'b0;
    @(negedge clk); rv = 1'b1; rw = 1'b0; ra = a;
    for (int k = 0; k < n * (E_RLEN + 1) + E_AA + 4; k++) begin
      if (drop) rv = 1'b0;
      if (rv && rdy) begin
        nacc++;
        if (last >= 0) chk(k - last == E_RLEN + 1, "R7", k - last, E_RLEN + 1, "accept spacing");
        last = k;
        if (nacc == n) drop = 1'b1;
      end
      if (rsp) begin
        nrsp++;
        chk(rdata == shadow[a], "R2", int'(rdata), int'(shadow[a]), "back-to-back read byte");
      end
      @(negedge clk);
    end
    chk(nrsp == n, "R9", nrsp, n, "back-to-back responses");
  endtask

  initial begin
    @(negedge clk);
    chk(ce && oe && we && !doe, "R1", {ce, oe, we, doe}, 4'b1110, "strobes in reset");
    chk(rdy && !rsp, "R1", {rdy, rsp}, 2'b10, "ready/valid in reset");
    wait (rst_n);
    @(negedge clk);
    chk(ce && oe && we && !doe && rdy && !rsp, "R1", {ce, oe, we, doe, rdy, rsp}, 6'b111010, "idle after reset");
    do_write(19'h00000, pat(19'h00000));
    do_write(19'h7FFFF, pat(19'h7FFFF));
    for (int i = 0; i < 19; i++) do_write(19'(1 << i), pat(19'(1 << i)));
    do_read(19'h00000);
    do_read(19'h7FFFF);
    for (int i = 0; i < 19; i++) do_read(19'(1 << i));
    do_write(19'h00000, 8'hFF);
    do_read(19'h00000);
    do_write(19'h00000, 8'h00);
    do_read(19'h00000);
    b2b(19'h7FFFF, 4);
    done = 1'b1;
  end
endmodule

module asram_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  bit   wd = 1'b0;
  always #4 clk = ~clk;

  asram_seq_tb_lane #(.OEL(1'b0)) u_lane_oeh (.clk(clk), .rst_n(rst_n));
  asram_seq_tb_lane #(.OEL(1'b1)) u_lane_oel (.clk(clk), .rst_n(rst_n));

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  end

  initial begin
    int c, f;
    fork
      wait (u_lane_oeh.done && u_lane_oel.done);
      begin repeat (20000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    c = u_lane_oeh.checks + u_lane_oel.checks;
    f = u_lane_oeh.fails + u_lane_oel.fails;
    if (wd) begin
      c++; f++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", c, f);
    $finish;
  end
endmodule